// File: doc/BRIEF.md
# Interrupt CPU interface

This block sits between an interrupt distributor and one processor. The distributor offers a single best candidate each cycle: a valid flag, an interrupt ID, its priority value and, for software-generated interrupts, the number of the CPU that raised it. The interface decides whether that candidate may interrupt the processor and drives a level interrupt request when it may. A candidate qualifies when signalling is enabled, when it beats the priority mask, and when it is more urgent than whatever the processor is already handling.

The processor reaches the interface through a 32-bit register port. Separate read and write strobes carry their own word addresses, so one read and one write can occur in the same cycle. Reading the acknowledge register claims the current candidate. The read returns its ID, records it as active, raises the running priority and tells the distributor to clear the pending state. If there is nothing to claim, the read returns a spurious marker and changes nothing. Writing the ID to the completion register retires the active entry, lowers the running priority again and tells the distributor that handling is finished.

Lower priority values are more urgent. Up to `SLOTS` interrupts can be active at once as nested preemptions. The running priority is the most urgent priority among the active entries, or 0xFF when none is active.

Top module: `cpu_irq_if`

## Requirements
- R1: Bit 0 of the control register (read address 0, write address 0) enables signalling. While it is 0, `irq` stays low and an acknowledge read returns the spurious marker.
- R2: The 8-bit priority mask (address 1) lets a candidate through only when the candidate's priority value is strictly less than the mask.
- R3: A read of the acknowledge register (read address 2) while a candidate qualifies does four things. It returns the ID in bits 9:0, makes the entry active, sets the running priority (read address 4) to the candidate's priority and pulses `ack_valid` with the ID.
- R4: An acknowledge read with no qualifying candidate returns 1023 (0x3FF) and leaves the running priority and active set unchanged.
- R5: Candidates with IDs 1020 to 1023 never raise `irq` and are never acknowledged.
- R6: A candidate qualifies only if its priority value is strictly less than the running priority.
- R7: Writing an active ID to the completion register (write address 3, ID in bits 9:0) removes that entry and pulses `eoi_valid` with the ID. The running priority becomes the most urgent remaining active priority, or 0xFF if none remains. The same candidate may then be signalled again.
- R8: A completion write whose ID is not active is ignored: no `eoi_valid` pulse and no change in running priority.
- R9: For IDs 0 to 15 the acknowledge value carries the source CPU in bits 12:10. For other IDs those bits are 0.
- R10: When all `SLOTS` active entries are in use, no candidate qualifies, whatever its priority.
- R11: A completion write and an acknowledge read in the same cycle both take effect. Qualification uses the state from before that cycle.
- R12: After reset the control register reads 0, the mask reads 0 and the running priority reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| cand_src | input | 3 | Source CPU of a software-generated candidate |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write word address |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Register read strobe |
| reg_raddr | input | 3 | Read word address |
| reg_rdata | output | 32 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Interrupt request to the processor |
| ack_valid | output | 1 | Pulse: an interrupt was claimed |
| ack_id | output | 10 | ID of the claimed interrupt |
| eoi_valid | output | 1 | Pulse: an active interrupt was completed |
| eoi_id | output | 10 | ID of the completed interrupt |

## Verification
The acknowledge read and the completion write can land in the same cycle. In that case one active entry is retired while a new, more urgent candidate is claimed. The bench provokes this by raising both strobes together while one interrupt is active and a preempting candidate is offered. It then checks three things: the read returns the new ID, both distributor pulses fire, and the running priority afterwards equals the new interrupt's priority rather than 0xFF.

// File: rtl/cpu_irq_if.sv
module cpu_irq_if #(
  parameter int ID_W      = 10,
  parameter int PRIO_W    = 8,
  parameter int SRC_W     = 3,
  parameter int SLOTS     = 4,
  parameter int SGI_IDS   = 16,
  parameter int RSV_FIRST = 1020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic [SRC_W-1:0]  cand_src,
  input  logic              reg_wr,
  input  logic [2:0]        reg_waddr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_rd,
  input  logic [2:0]        reg_raddr,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              ack_valid,
  output logic [ID_W-1:0]   ack_id,
  output logic              eoi_valid,
  output logic [ID_W-1:0]   eoi_id
);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int PAD_W  = 32 - SRC_W - ID_W;
  localparam logic [2:0] A_CTRL = 3'd0, A_PMASK = 3'd1, A_ACK = 3'd2,
                         A_EOI = 3'd3, A_RUNPRI = 3'd4;
  localparam logic [ID_W-1:0]   SPURIOUS = '1;
  localparam logic [PRIO_W-1:0] IDLE_PRI = '1;

  logic              ctrl_en;
  logic [PRIO_W-1:0] pmask;
  logic [SLOTS-1:0]  slot_v;
  logic [ID_W-1:0]   slot_id  [SLOTS];
  logic [PRIO_W-1:0] slot_pri [SLOTS];

  logic [PRIO_W-1:0] running;
  logic              free_ok, eoi_hit;
  logic [SLOT_W-1:0] free_idx, eoi_idx;
  logic              wr_eoi, rd_ack, elig, take;
  logic [SRC_W-1:0]  src_field;
  logic [31:0]       ack_word;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[31:ID_W];

  always_comb begin
    running  = IDLE_PRI;
    free_ok  = 1'b0;
    free_idx = '0;
    eoi_hit  = 1'b0;
    eoi_idx  = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (slot_v[i] && slot_pri[i] < running) running = slot_pri[i];
      if (!slot_v[i]) begin
        free_ok  = 1'b1;
        free_idx = SLOT_W'(i);
      end
      if (slot_v[i] && slot_id[i] == reg_wdata[ID_W-1:0]) begin
        eoi_hit = 1'b1;
        eoi_idx = SLOT_W'(i);
      end
    end
  end

  assign wr_eoi = reg_wr && reg_waddr == A_EOI;
  assign rd_ack = reg_rd && reg_raddr == A_ACK;
  assign elig   = ctrl_en && cand_valid && cand_id < ID_W'(RSV_FIRST) &&
                  cand_prio < pmask && cand_prio < running && free_ok;
  assign take   = rd_ack && elig;

  assign src_field = (cand_id < ID_W'(SGI_IDS)) ? cand_src : SRC_W'(0);
  assign ack_word  = take ? {{PAD_W{1'b0}}, src_field, cand_id}
                          : {{(32-ID_W){1'b0}}, SPURIOUS};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
      pmask   <= '0;
    end else if (reg_wr) begin
      if (reg_waddr == A_CTRL)  ctrl_en <= reg_wdata[0];
      if (reg_waddr == A_PMASK) pmask   <= reg_wdata[PRIO_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_v <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        slot_id[i]  <= '0;
        slot_pri[i] <= '0;
      end
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (wr_eoi && eoi_hit && eoi_idx == SLOT_W'(i)) slot_v[i] <= 1'b0;
        if (take && free_idx == SLOT_W'(i)) begin
          slot_v[i]   <= 1'b1;
          slot_id[i]  <= cand_id;
          slot_pri[i] <= cand_prio;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq       <= 1'b0;
      ack_valid <= 1'b0;
      ack_id    <= '0;
      eoi_valid <= 1'b0;
      eoi_id    <= '0;
      reg_rdata <= '0;
    end else begin
      irq       <= elig;
      ack_valid <= take;
      ack_id    <= cand_id;
      eoi_valid <= wr_eoi && eoi_hit;
      eoi_id    <= reg_wdata[ID_W-1:0];
      if (reg_rd) begin
        case (reg_raddr)
          A_CTRL:   reg_rdata <= {31'b0, ctrl_en};
          A_PMASK:  reg_rdata <= {{(32-PRIO_W){1'b0}}, pmask};
          A_ACK:    reg_rdata <= ack_word;
          A_RUNPRI: reg_rdata <= {{(32-PRIO_W){1'b0}}, running};
          default:  reg_rdata <= '0;
        endcase
      end
    end
  end

  // R1
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !irq);

  // R2
  pmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cand_prio) < $past(pmask));

  // R3
  ack_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> running == $past(cand_prio) && ack_valid);

  // R4
  spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack && !elig |=> reg_rdata == {{(32-ID_W){1'b0}}, SPURIOUS} && $stable(slot_v));

  // R5
  rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> ack_id < ID_W'(RSV_FIRST));

  // R8
  eoi_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_eoi && !eoi_hit && !take |=> $stable(slot_v) && !eoi_valid);
endmodule

// File: tb/cpu_irq_if_tb_top.sv
`timescale 1ns/1ps
module cpu_irq_if_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cand_valid = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [7:0]  cand_prio = '0;
  logic [2:0]  cand_src = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_waddr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, ack_valid, eoi_valid;
  logic [9:0]  ack_id, eoi_id;

  int n_chk = 0, n_fail = 0;
  logic [31:0] rd_val;
  logic        got_ack, got_eoi;
  logic [9:0]  got_ack_id, got_eoi_id;

  always #2.5 clk = ~clk;

  cpu_irq_if dut_i (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_id(cand_id),
    .cand_prio(cand_prio), .cand_src(cand_src), .reg_wr(reg_wr),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .irq(irq),
    .ack_valid(ack_valid), .ack_id(ack_id), .eoi_valid(eoi_valid), .eoi_id(eoi_id));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk);
    reg_rd = 1'b1; reg_raddr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    rd_val = reg_rdata; got_ack = ack_valid; got_ack_id = ack_id;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    got_eoi = eoi_valid; got_eoi_id = eoi_id;
  endtask

  task automatic offer(input logic [9:0] id, input logic [7:0] p, input logic [2:0] s);
    cand_valid = 1'b1; cand_id = id; cand_prio = p; cand_src = s;
  endtask

  task automatic drop();
    cand_valid = 1'b0;
  endtask

  task automatic claim(input logic [9:0] id, input logic [7:0] p);
    offer(id, p, 3'd0);
    idle(2);
    rd(3'd2);
    drop();
    chk("R3 claim id", rd_val, {22'b0, id});
  endtask

  task automatic t_reset();
    chk("R1 irq after reset", {31'b0, irq}, 0);
    rd(3'd0); chk("R12 ctrl reset", rd_val, 0);
    rd(3'd1); chk("R12 mask reset", rd_val, 0);
    rd(3'd4); chk("R12 runpri reset", rd_val, 32'hFF);
    rd(3'd2); chk("R4 spurious at reset", rd_val, 32'd1023);
    rd(3'd4); chk("R4 runpri unchanged", rd_val, 32'hFF);
  endtask

  task automatic t_enable();
    offer(10'd45, 8'h40, 3'd0);
    wr(3'd1, 32'hF0);
    idle(3);
    chk("R1 irq low while disabled", {31'b0, irq}, 0);
    rd(3'd2); chk("R1 ack spurious while disabled", rd_val, 32'd1023);
    wr(3'd0, 32'h1);
    idle(2);
    chk("R1 irq when enabled", {31'b0, irq}, 1);
    rd(3'd0); chk("R12 ctrl readback", rd_val, 1);
  endtask

  task automatic t_mask();
    wr(3'd1, 32'h40); idle(2);
    chk("R2 equal to mask blocked", {31'b0, irq}, 0);
    wr(3'd1, 32'h41); idle(2);
    chk("R2 below mask passes", {31'b0, irq}, 1);
    wr(3'd1, 32'hF0); idle(2);
  endtask

  task automatic t_ack();
    rd(3'd2);
    drop();
    chk("R3 ack id", rd_val, 32'd45);
    chk("R3 ack pulse", {got_ack, 21'b0, got_ack_id}, {1'b1, 21'b0, 10'd45});
    rd(3'd4); chk("R3 runpri", rd_val, 32'h40);
    chk("R3 irq dropped", {31'b0, irq}, 0);
  endtask

  task automatic t_preempt();
    offer(10'd50, 8'h40, 3'd0); idle(2);
    chk("R6 equal running blocked", {31'b0, irq}, 0);
    offer(10'd50, 8'h30, 3'd0); idle(2);
    chk("R6 more urgent signalled", {31'b0, irq}, 1);
    rd(3'd2); drop();
    chk("R6 preempt ack", rd_val, 32'd50);
    rd(3'd4); chk("R6 runpri nested", rd_val, 32'h30);
  endtask

  task automatic t_eoi();
    wr(3'd3, 32'd46);
    chk("R8 no pulse", {31'b0, got_eoi}, 0);
    rd(3'd4); chk("R8 runpri kept", rd_val, 32'h30);
    wr(3'd3, 32'd50);
    chk("R7 eoi pulse", {got_eoi, 21'b0, got_eoi_id}, {1'b1, 21'b0, 10'd50});
    rd(3'd4); chk("R7 runpri to remaining", rd_val, 32'h40);
    wr(3'd3, 32'd45);
    rd(3'd4); chk("R7 runpri idle", rd_val, 32'hFF);
    offer(10'd45, 8'h40, 3'd0); idle(2);
    chk("R7 resignal", {31'b0, irq}, 1);
    rd(3'd2); drop();
    chk("R7 reack", rd_val, 32'd45);
    wr(3'd3, 32'd45);
    wr(3'd3, 32'd45);
    chk("R8 repeat eoi ignored", {31'b0, got_eoi}, 0);
    rd(3'd4); chk("R8 runpri idle", rd_val, 32'hFF);
  endtask

  task automatic t_reserved();
    offer(10'd1020, 8'h10, 3'd0); idle(2);
    chk("R5 reserved no irq", {31'b0, irq}, 0);
    rd(3'd2); chk("R5 reserved spurious", rd_val, 32'd1023);
    rd(3'd4); chk("R5 runpri kept", rd_val, 32'hFF);
    offer(10'd1019, 8'h10, 3'd0); idle(2);
    chk("R5 top valid irq", {31'b0, irq}, 1);
    rd(3'd2); drop();
    chk("R5 top valid ack", rd_val, 32'd1019);
    wr(3'd3, 32'd1019);
  endtask

  task automatic t_sgi();
    offer(10'd3, 8'h50, 3'd5); idle(2);
    rd(3'd2); drop();
    chk("R9 sgi source", rd_val, 32'h1403);
    wr(3'd3, 32'h1403);
    chk("R9 sgi eoi", {31'b0, got_eoi}, 1);
    offer(10'd16, 8'h50, 3'd5); idle(2);
    rd(3'd2); drop();
    chk("R9 non-sgi no source", rd_val, 32'h10);
    wr(3'd3, 32'h10);
    rd(3'd4); chk("R9 runpri idle", rd_val, 32'hFF);
  endtask

  task automatic t_full();
    claim(10'd100, 8'h40);
    claim(10'd101, 8'h30);
    claim(10'd102, 8'h20);
    claim(10'd103, 8'h10);
    offer(10'd104, 8'h08, 3'd0); idle(2);
    chk("R10 full no irq", {31'b0, irq}, 0);
    rd(3'd2); chk("R10 full spurious", rd_val, 32'd1023);
    wr(3'd3, 32'd101);
    rd(3'd4); chk("R7 middle eoi runpri", rd_val, 32'h10);
    idle(1);
    chk("R10 slot freed irq", {31'b0, irq}, 1);
    rd(3'd2); drop();
    chk("R10 ack after free", rd_val, 32'd104);
    wr(3'd3, 32'd104); wr(3'd3, 32'd103); wr(3'd3, 32'd102); wr(3'd3, 32'd100);
    rd(3'd4); chk("R7 all retired", rd_val, 32'hFF);
  endtask

  task automatic t_same();
    claim(10'd200, 8'h40);
    offer(10'd201, 8'h20, 3'd0); idle(2);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = 3'd3; reg_wdata = 32'd200;
    reg_rd = 1'b1; reg_raddr = 3'd2;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    drop();
    chk("R11 same-cycle ack", reg_rdata, 32'd201);
    chk("R11 same-cycle eoi pulse", {eoi_valid, 21'b0, eoi_id}, {1'b1, 21'b0, 10'd200});
    chk("R11 same-cycle ack pulse", {31'b0, ack_valid}, 1);
    rd(3'd4); chk("R11 runpri new", rd_val, 32'h20);
    wr(3'd3, 32'd201);
    rd(3'd4); chk("R11 runpri idle", rd_val, 32'hFF);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_enable();
    t_mask();
    t_ack();
    t_preempt();
    t_eoi();
    t_reserved();
    t_sgi();
    t_full();
    t_same();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule